// File: doc/BRIEF.md
# Shared Serial Link Hub with Write Lock

This block lets several client threads of one chip share a single asynchronous serial link. On the outgoing side, a lock arbiter hands the transmitter to one client at a time. A client keeps the lock until it gives it back. Only the lock owner can start a byte on the line. There is no transmit queue, so a writer waits for `write_ready` and presents one byte at a time.

On the incoming side, a receiver watches `serial_in` and stores every good byte in a read queue. Any client may take the bytes from the head of that queue. The receiver arms only when the local transmitter is idle and the queue has room. The `rts` output tells the far end when this is true.

Each bit on either line lasts `TICKS_PER_BIT` clock cycles. A frame holds a low start bit, eight data bits sent least significant first, and a low finish bit. The line idles high.

Top module: `uart_lock_hub`

## Requirements
- R1: After reset, `serial_out` is 1, `write_ready` is 1, `lock_grant` is all zeros, `rd_valid` is 0 and `rts` is 1.
- R2: When no client holds the lock, one or more requests in a cycle grant it to the lowest-numbered requester. Bit i of `lock_grant` shows client i as owner from the next cycle on.
- R3: The owner keeps the lock until it raises its own `lock_rel` bit. Releases from other clients and requests made while the lock is held have no effect. The cycle in which the lock is released grants it to nobody.
- R4: A byte starts on `serial_out` only when its client owns the lock, that client's `wr_valid` bit is set, and `write_ready` is 1. Valid bytes from non-owners, or sent while nobody holds the lock, leave the line idle.
- R5: A transmitted frame is: start bit 0, then `wr_data` byte bits 0 to 7, then finish bit 0. Each bit lasts `TICKS_PER_BIT` cycles. `write_ready` stays 0 for the whole frame.
- R6: A valid byte offered while `write_ready` is 0 is dropped and never sent.
- R7: `rts` is 1 exactly when the transmitter is idle and the read queue is not full. A frame that begins while `rts` is 0 is not received.
- R8: The receiver begins a frame only on a high-to-low change of `serial_in` and samples each bit at its middle. A low pulse shorter than half a bit is ignored.
- R9: A frame with start bit 0, data LSB first and finish bit 0 puts its byte in the read queue. A frame whose finish bit reads 1 is discarded.
- R10: The read queue keeps arrival order and holds up to `FIFO_DEPTH` bytes. `rd_data` shows the head byte while `rd_valid` is 1. `rd_pop` removes the head byte.
- R11: `rd_pop` on an empty queue is ignored. The next received byte is the one presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_req | input | NUM_CLIENTS | Per-client lock request |
| lock_rel | input | NUM_CLIENTS | Per-client lock release |
| lock_grant | output | NUM_CLIENTS | One-hot current lock owner |
| wr_valid | input | NUM_CLIENTS | Per-client byte valid |
| wr_data | input | 8*NUM_CLIENTS | Per-client byte, client i in bits 8i+7..8i |
| write_ready | output | 1 | Transmitter idle, a byte may be offered |
| serial_out | output | 1 | Outgoing serial line |
| serial_in | input | 1 | Incoming serial line |
| rts | output | 1 | Receiver armed, far end may send |
| rd_pop | input | 1 | Remove head byte of read queue |
| rd_data | output | 8 | Head byte of read queue |
| rd_valid | output | 1 | Read queue not empty |

## Verification
The bench builds the hub with four clients, eight cycles per bit and a read queue of four entries. With a short bit, many whole frames fit in a short run, in both directions and during transmit-busy windows. With a shallow queue, filling it, the loss of the extra frame, and the `rts` drop and recovery can each be reached in a few frames. Four clients are enough to test lowest-number priority, ignored non-owner releases, and a release and request arriving in the same cycle.

// File: rtl/uart_hub_pkg.sv
package uart_hub_pkg;

  localparam int BYTE_W = 8;
  localparam logic [3:0] LAST_BIT = 4'd9;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_FINISH
  } rx_state_t;

  // Line level for bit position idx of a frame carrying byte b.
  function automatic logic frame_level(input logic [7:0] b, input logic [3:0] idx);
    logic [2:0] k;
    if (idx == 4'd0 || idx >= LAST_BIT) return 1'b0;
    k = 3'(idx - 4'd1);
    return b[k];
  endfunction

  // Index of the lowest set bit (0 when none set).
  function automatic logic [4:0] lowest_index(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/uart_hub_lock.sv
module uart_hub_lock #(
  parameter int NUM_CLIENTS = 4,
  localparam int OW = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLIENTS-1:0] req,
  input  logic [NUM_CLIENTS-1:0] rel,
  output logic [NUM_CLIENTS-1:0] grant,
  output logic                   held,
  output logic [OW-1:0]          owner
);
  import uart_hub_pkg::*;

  logic          held_q;
  logic [OW-1:0] owner_q;
  logic          owner_releases;

  assign owner_releases = held_q && rel[owner_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      owner_q <= '0;
    end else if (!held_q) begin
      if (|req) begin
        held_q  <= 1'b1;
        owner_q <= OW'(lowest_index(32'(req)));
      end
    end else if (owner_releases) begin
      held_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_grant
    assign grant[i] = held_q && (owner_q == OW'(i));
  end

  assign held  = held_q;
  assign owner = owner_q;

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_lock_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rel[owner_q]) |=> (held_q && $stable(owner_q)));

  p_release_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
    owner_releases |=> (grant == '0));

endmodule

// File: rtl/uart_hub_tx.sv
module uart_hub_tx #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_in,
  output logic       line,
  output logic       idle
);
  import uart_hub_pkg::*;

  logic             busy;
  logic [3:0]       bit_idx;
  logic [CNT_W-1:0] tick;
  logic [7:0]       data;
  logic             bit_end;

  assign bit_end = (tick == CNT_W'(TICKS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      tick    <= '0;
      data    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        bit_idx <= '0;
        tick    <= '0;
        data    <= byte_in;
      end
    end else if (bit_end) begin
      tick <= '0;
      if (bit_idx == LAST_BIT) busy <= 1'b0;
      else bit_idx <= bit_idx + 4'd1;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  assign line = busy ? frame_level(data, bit_idx) : 1'b1;
  assign idle = !busy;

  p_start_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  p_start_goes_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!line && !idle));

  p_bit_index_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bit_idx <= LAST_BIT));

endmodule

// File: rtl/uart_hub_rx.sv
module uart_hub_rx #(
  parameter int TICKS_PER_BIT = 16,
  localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1,
  localparam int HALF  = TICKS_PER_BIT / 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       armed,
  output logic       push,
  output logic [7:0] byte_out
);
  import uart_hub_pkg::*;

  logic             s_meta, s_sync, s_last;
  logic             fall;
  rx_state_t        state;
  logic [CNT_W-1:0] tick;
  logic [2:0]       bit_cnt;
  logic [7:0]       shift;
  logic             push_q;
  logic             bit_end;
  logic             half_end;

  assign fall     = s_last && !s_sync;
  assign bit_end  = (tick == CNT_W'(TICKS_PER_BIT - 1));
  assign half_end = (tick == CNT_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_meta <= 1'b1;
      s_sync <= 1'b1;
      s_last <= 1'b1;
    end else begin
      s_meta <= line_in;
      s_sync <= s_meta;
      s_last <= s_sync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      tick    <= '0;
      bit_cnt <= '0;
      shift   <= '0;
      push_q  <= 1'b0;
    end else begin
      push_q <= 1'b0;
      case (state)
        RX_IDLE: begin
          tick <= '0;
          if (armed && fall) state <= RX_START;
        end
        RX_START: begin
          if (half_end) begin
            tick    <= '0;
            bit_cnt <= '0;
            state   <= s_sync ? RX_IDLE : RX_DATA;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            tick  <= '0;
            shift <= {s_sync, shift[7:1]};
            if (bit_cnt == 3'd7) state <= RX_FINISH;
            else bit_cnt <= bit_cnt + 3'd1;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        RX_FINISH: begin
          if (bit_end) begin
            tick   <= '0;
            push_q <= !s_sync;
            state  <= RX_IDLE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign push     = push_q;
  assign byte_out = shift;

  p_start_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && $past(state) == RX_IDLE) |-> $past(armed));

  p_push_ends_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (state == RX_IDLE && $past(state) == RX_FINISH));

endmodule

// File: rtl/uart_hub_fifo.sv
module uart_hub_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] dout,
  output logic       empty,
  output logic       full
);
  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  p_empty_pop_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/uart_lock_hub.sv
module uart_lock_hub #(
  parameter int NUM_CLIENTS   = 4,
  parameter int TICKS_PER_BIT = 16,
  parameter int FIFO_DEPTH    = 16,
  localparam int OW = (NUM_CLIENTS > 1) ? $clog2(NUM_CLIENTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CLIENTS-1:0]   lock_req,
  input  logic [NUM_CLIENTS-1:0]   lock_rel,
  output logic [NUM_CLIENTS-1:0]   lock_grant,
  input  logic [NUM_CLIENTS-1:0]   wr_valid,
  input  logic [8*NUM_CLIENTS-1:0] wr_data,
  output logic                     write_ready,
  output logic                     serial_out,
  input  logic                     serial_in,
  output logic                     rts,
  input  logic                     rd_pop,
  output logic [7:0]               rd_data,
  output logic                     rd_valid
);
  logic          held;
  logic [OW-1:0] owner;
  logic          tx_idle;
  logic          tx_fire;
  logic [7:0]    tx_byte;
  logic          rx_armed;
  logic          rx_push;
  logic [7:0]    rx_byte;
  logic          q_empty, q_full;

  uart_hub_lock #(.NUM_CLIENTS(NUM_CLIENTS)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (lock_req),
    .rel   (lock_rel),
    .grant (lock_grant),
    .held  (held),
    .owner (owner)
  );

  assign tx_fire = held && wr_valid[owner] && tx_idle;
  assign tx_byte = wr_data[int'(owner)*8 +: 8];

  uart_hub_tx #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_fire),
    .byte_in (tx_byte),
    .line    (serial_out),
    .idle    (tx_idle)
  );

  assign rx_armed = tx_idle && !q_full;

  uart_hub_rx #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (serial_in),
    .armed    (rx_armed),
    .push     (rx_push),
    .byte_out (rx_byte)
  );

  uart_hub_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (rd_pop),
    .dout  (rd_data),
    .empty (q_empty),
    .full  (q_full)
  );

  assign write_ready = tx_idle;
  assign rts         = rx_armed;
  assign rd_valid    = !q_empty;

  p_write_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_ready) |-> $past(|(lock_grant & wr_valid)));

  p_rts_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !write_ready |-> !rts);

endmodule

// File: tb/uart_lock_hub_bench.sv
module uart_lock_hub_bench;
  localparam int N = 4;
  localparam int T = 8;
  localparam int D = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   lock_req = '0, lock_rel = '0, wr_valid = '0;
  logic [N-1:0]   lock_grant;
  logic [8*N-1:0] wr_data = '0;
  logic           write_ready, serial_out, rts, rd_valid;
  logic           serial_in = 1'b1;
  logic           rd_pop = 1'b0;
  logic [7:0]     rd_data;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_lock_hub #(.NUM_CLIENTS(N), .TICKS_PER_BIT(T), .FIFO_DEPTH(D)) u_uart_lock_hub (
    .clk(clk), .rst_n(rst_n), .lock_req(lock_req), .lock_rel(lock_rel),
    .lock_grant(lock_grant), .wr_valid(wr_valid), .wr_data(wr_data),
    .write_ready(write_ready), .serial_out(serial_out), .serial_in(serial_in),
    .rts(rts), .rd_pop(rd_pop), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // {req, rel, expected grant after one edge}
  localparam logic [11:0] LOCK_VEC [11] = '{
    {4'b0000, 4'b0000, 4'b0000},
    {4'b0110, 4'b0000, 4'b0010},
    {4'b0001, 4'b0000, 4'b0010},
    {4'b0000, 4'b0001, 4'b0010},
    {4'b0000, 4'b0010, 4'b0000},
    {4'b1100, 4'b0000, 4'b0100},
    {4'b0001, 4'b0100, 4'b0000},
    {4'b0001, 4'b0000, 4'b0001},
    {4'b0000, 4'b0001, 4'b0000},
    {4'b1000, 4'b0000, 4'b1000},
    {4'b0000, 4'b1000, 4'b0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic fin);
    serial_in = 1'b0; step(T);
    for (int i = 0; i < 8; i++) begin serial_in = b[i]; step(T); end
    serial_in = fin; step(T);
    serial_in = 1'b1;
  endtask

  task automatic take_lock(input int c);
    lock_req[c] = 1'b1; step(1); lock_req = '0;
  endtask

  task automatic drop_lock(input int c);
    lock_rel[c] = 1'b1; step(1); lock_rel = '0;
  endtask

  task automatic pop_one;
    rd_pop = 1'b1; step(1); rd_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic       lvl;
    int         lows;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 serial_out", serial_out, 1);
    chk("R1 write_ready", write_ready, 1);
    chk("R1 lock_grant", lock_grant, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rts", rts, 1);

    // R2/R3 lock vector walk
    for (int i = 0; i < 11; i++) begin
      lock_req = LOCK_VEC[i][11:8];
      lock_rel = LOCK_VEC[i][7:4];
      step(1);
      lock_req = '0; lock_rel = '0;
      chk($sformatf("R2/R3 lock row %0d", i), lock_grant, LOCK_VEC[i][3:0]);
    end

    // R4 no owner: valid bytes ignored
    wr_valid = '1; wr_data = 32'h11223344;
    lows = 0;
    for (int i = 0; i < 4; i++) begin step(1); if (!serial_out) lows++; end
    wr_valid = '0;
    chk("R4 no owner line idle", lows, 0);
    chk("R4 no owner write_ready", write_ready, 1);

    // R4 non-owner valid ignored
    take_lock(1);
    wr_data[7:0] = 8'h55; wr_valid[0] = 1'b1;
    lows = 0;
    for (int i = 0; i < 4; i++) begin step(1); if (!serial_out) lows++; end
    wr_valid = '0;
    chk("R4 non-owner line idle", lows, 0);

    // R5 owner transmits 0xA6
    wr_data[15:8] = 8'hA6; wr_valid[1] = 1'b1;
    step(1); wr_valid = '0;
    chk("R5 write_ready low in frame", write_ready, 0);
    step(T/2);
    chk("R5 start bit", serial_out, 0);
    got = '0;
    for (int i = 0; i < 8; i++) begin step(T); got[i] = serial_out; end
    chk("R5 data bits LSB first", got, 8'hA6);
    step(T); lvl = serial_out;
    chk("R5 finish bit", lvl, 0);
    // R6 offer while busy
    chk("R6 still busy", write_ready, 0);
    wr_data[15:8] = 8'h3C; wr_valid[1] = 1'b1; step(1); wr_valid = '0;
    step(T);
    chk("R5 write_ready back", write_ready, 1);
    lows = 0;
    for (int i = 0; i < 3*T; i++) begin step(1); if (!serial_out) lows++; end
    chk("R6 dropped byte not sent", lows, 0);
    drop_lock(1);

    // R9 normal receive
    send_rx(8'h2A, 1'b0); step(4);
    chk("R9 byte present", rd_valid, 1);
    chk("R9 byte value", rd_data, 8'h2A);
    pop_one;
    chk("R10 pop empties", rd_valid, 0);

    // R9 finish bit 1 discarded
    send_rx(8'h77, 1'b1); step(4);
    chk("R9 bad finish dropped", rd_valid, 0);

    // R8 short glitch ignored
    serial_in = 1'b0; step(2); serial_in = 1'b1; step(2*T);
    chk("R8 glitch ignored", rd_valid, 0);
    send_rx(8'h81, 1'b0); step(4);
    chk("R8 recovers after glitch", rd_data, 8'h81);
    pop_one;

    // R11 pop on empty
    rd_pop = 1'b1; step(2); rd_pop = 1'b0;
    chk("R11 still empty", rd_valid, 0);
    send_rx(8'h5A, 1'b0); step(4);
    chk("R11 next byte valid", rd_valid, 1);
    chk("R11 next byte value", rd_data, 8'h5A);
    pop_one;
    chk("R11 single entry", rd_valid, 0);

    // R10/R7 fill queue
    send_rx(8'h11, 1'b0); step(2);
    send_rx(8'h22, 1'b0); step(2);
    send_rx(8'h33, 1'b0); step(2);
    send_rx(8'h44, 1'b0); step(4);
    chk("R7 rts low when full", rts, 0);
    send_rx(8'h99, 1'b0); step(4);
    for (int i = 0; i < D; i++) begin
      chk($sformatf("R10 order entry %0d", i), rd_data, 32'(8'h11 * (i + 1)));
      pop_one;
    end
    chk("R7 extra frame lost", rd_valid, 0);
    chk("R7 rts back", rts, 1);

    // R7 receive blocked while transmitting
    take_lock(3);
    wr_data[31:24] = 8'hC3; wr_valid[3] = 1'b1; step(1); wr_valid = '0;
    chk("R7 rts low while tx busy", rts, 0);
    step(1);
    send_rx(8'hFF, 1'b0);
    step(4);
    chk("R7 no receive during tx", rd_valid, 0);
    drop_lock(3);
    chk("R3 lock released", lock_grant, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule